// File: doc/BRIEF.md
# Tagged Page Translation Buffer

This block is a small, fully associative store of page translations that sits in front of a page table walker. A requester presents a virtual page number, the address-space identifier of the running process and the kind of access (read, write or execute). In the same cycle the block compares the request against every entry and answers with a hit or a miss. On a hit it also returns the physical frame number and a fault flag. The flag is raised when the stored read, write and execute bits do not allow the requested access.

An entry answers a request only when its identifier matches the requester's, unless its global bit is set. A global entry answers every address space. When a miss has been resolved elsewhere, the new translation is loaded through the fill port. The fill takes the lowest-numbered empty slot. When no slot is empty, it takes the slot named by a round-robin pointer. Two invalidate strobes are provided. One empties the whole store. The other empties only the non-global entries that belong to one address space.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty, so any valid lookup reports a miss.
- R2: An entry matches a lookup when it is valid, its page number equals `lk_vpn`, and its global bit is set or its identifier equals `lk_asid`. `lk_hit` is high in the same cycle if any entry matches. `lk_miss` is high when `lk_valid` is high and no entry matches.
- R3: On a hit, `lk_pfn` carries the frame number of the matching entry. With no hit, `lk_pfn` is zero.
- R4: `lk_kind` is encoded as 0 = read, 1 = write, 2 = execute, 3 = always denied. On a hit, `lk_fault` is high when the matching entry's bit for that kind is clear. `lk_fault` is never high without a hit.
- R5: A fill presented with `fl_en` in one cycle is visible to lookups from the next cycle.
- R6: A fill writes the lowest-indexed invalid entry whenever one exists.
- R7: When every entry is valid, a fill replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset, advances by one (wrapping) on each such replacement, and does not move on other fills.
- R8: `fa_en` invalidates every entry, and lookups miss from the next cycle.
- R9: `fi_en` invalidates only the entries whose global bit is clear and whose identifier equals `fi_asid`. Global entries and entries of other identifiers are kept.
- R10: When several entries match, the one with the lowest index supplies the frame number and permission bits.
- R11: While `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` stay low.
- R12: If a fill and an invalidate occur in the same cycle, the slot is chosen from the state before the invalidate, and the newly filled entry stays valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Address-space identifier of the requester |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 denied |
| lk_hit | output | 1 | A valid entry matched |
| lk_miss | output | 1 | Lookup requested and nothing matched |
| lk_pfn | output | PFN_W | Frame number of the winning entry, zero on no hit |
| lk_fault | output | 1 | Hit whose permission bits reject the access |
| fl_en | input | 1 | Load a new translation |
| fl_vpn | input | VPN_W | Page number to load |
| fl_pfn | input | PFN_W | Frame number to load |
| fl_asid | input | ASID_W | Identifier to load |
| fl_rd | input | 1 | Readable bit to load |
| fl_wr | input | 1 | Writable bit to load |
| fl_ex | input | 1 | Executable bit to load |
| fl_glb | input | 1 | Global bit to load |
| fa_en | input | 1 | Invalidate every entry |
| fi_en | input | 1 | Invalidate the non-global entries of one identifier |
| fi_asid | input | ASID_W | Identifier to invalidate |

## Verification
The assertions check on every cycle that hit and miss never appear together and that no outcome is signalled when no request is present. They also check that a fault only accompanies a hit, that the frame output is zero when nothing hits, and that a load is found on the next cycle and a full invalidate empties the store. Several behaviours can only be shown by the bench's scenarios: which slot a fill lands in, the order in which the round-robin pointer evicts entries, the lowest-index rule between duplicates, and the way a per-identifier invalidate spares global entries. The bench shows these through later hits and misses, compared against a reference model kept in the bench.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 24,
  parameter int ASID_W = 16,
  parameter int N_ENT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_kind,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_fault,
  input  logic              fl_en,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PFN_W-1:0]  fl_pfn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic              fl_rd,
  input  logic              fl_wr,
  input  logic              fl_ex,
  input  logic              fl_glb,
  input  logic              fa_en,
  input  logic              fi_en,
  input  logic [ASID_W-1:0] fi_asid
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0]  vld, glb, prd, pwr, pex, hitv;
  logic [VPN_W-1:0]  e_vpn  [N_ENT];
  logic [PFN_W-1:0]  e_pfn  [N_ENT];
  logic [ASID_W-1:0] e_asid [N_ENT];
  logic [IDX_W-1:0]  rr, sel, free_idx, victim;
  logic              allowed;
  wire               full = &vld;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hitv[i] = vld[i] && e_vpn[i] == lk_vpn && (glb[i] || e_asid[i] == lk_asid);
  end

  always_comb begin
    sel = '0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hitv[i]) sel = IDX_W'(i);
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    case (lk_kind)
      2'd0:    allowed = prd[sel];
      2'd1:    allowed = pwr[sel];
      2'd2:    allowed = pex[sel];
      default: allowed = 1'b0;
    endcase
  end

  assign victim   = full ? rr : free_idx;
  assign lk_hit   = lk_valid && |hitv;
  assign lk_miss  = lk_valid && !(|hitv);
  assign lk_pfn   = lk_hit ? e_pfn[sel] : '0;
  assign lk_fault = lk_hit && !allowed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (fa_en || (fi_en && !glb[i] && e_asid[i] == fi_asid)) vld[i] <= 1'b0;
        if (fl_en && victim == IDX_W'(i)) vld[i] <= 1'b1;
      end
      if (fl_en && full) rr <= (rr == IDX_W'(N_ENT - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_en) begin
      e_vpn[victim]  <= fl_vpn;
      e_pfn[victim]  <= fl_pfn;
      e_asid[victim] <= fl_asid;
      prd[victim]    <= fl_rd;
      pwr[victim]    <= fl_wr;
      pex[victim]    <= fl_ex;
      glb[victim]    <= fl_glb;
    end
  end
endmodule

module xlat_cache_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 24,
  parameter int ASID_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [PFN_W-1:0]  lk_pfn,
  input logic              lk_fault,
  input logic              fl_en,
  input logic [VPN_W-1:0]  fl_vpn,
  input logic [ASID_W-1:0] fl_asid,
  input logic              fa_en
);
  a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit && !lk_miss && !lk_fault);
  a_r4_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
  a_r3_pfn_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_pfn == '0);
  a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en |=> !(lk_valid && lk_vpn == $past(fl_vpn) && lk_asid == $past(fl_asid)) || lk_hit);
  a_r8_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fa_en && !fl_en |=> !lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_fault(lk_fault),
  .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fa_en(fa_en)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int VW = 20, PW = 24, AW = 16, N = 16;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fl_en = 0, fl_rd = 0, fl_wr = 0, fl_ex = 0, fl_glb = 0, fa_en = 0, fi_en = 0;
  logic [VW-1:0] lk_vpn = 0, fl_vpn = 0;
  logic [AW-1:0] lk_asid = 0, fl_asid = 0, fi_asid = 0;
  logic [PW-1:0] fl_pfn = 0;
  logic [1:0] lk_kind = 0;
  logic lk_hit, lk_miss, lk_fault;
  logic [PW-1:0] lk_pfn;

  int checks = 0, fails = 0;

  logic          m_v [N], m_r [N], m_w [N], m_x [N], m_g [N];
  logic [VW-1:0] m_vpn [N];
  logic [PW-1:0] m_pfn [N];
  logic [AW-1:0] m_asid [N];
  int            m_rr;

  xlat_cache u0 (.*);

  always #5 clk = ~clk;

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [VW-1:0] v, input logic [AW-1:0] a);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) return i;
    return -1;
  endfunction

  function automatic logic m_allow(input int i, input logic [1:0] k);
    case (k)
      2'd0: return m_r[i];
      2'd1: return m_w[i];
      2'd2: return m_x[i];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_check();
    int  idx = m_find(lk_vpn, lk_asid);
    logic eh = lk_valid && idx >= 0;
    chk("R2 hit", PW'(lk_hit), PW'(eh));
    chk("R11 miss", PW'(lk_miss), PW'(lk_valid && idx < 0));
    chk("R3 pfn", lk_pfn, eh ? m_pfn[idx] : '0);
    chk("R4 fault", PW'(lk_fault), PW'(eh && !m_allow(idx, lk_kind)));
  endtask

  task automatic model_update();
    int vic = -1;
    bit full = 1;
    for (int i = 0; i < N; i++) if (!m_v[i]) full = 0;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
    if (full) vic = m_rr;
    for (int i = 0; i < N; i++)
      if (fa_en || (fi_en && !m_g[i] && m_asid[i] == fi_asid)) m_v[i] = 0;
    if (fl_en) begin
      m_v[vic] = 1; m_vpn[vic] = fl_vpn; m_pfn[vic] = fl_pfn; m_asid[vic] = fl_asid;
      m_r[vic] = fl_rd; m_w[vic] = fl_wr; m_x[vic] = fl_ex; m_g[vic] = fl_glb;
      if (full) m_rr = (m_rr + 1) % N;
    end
  endtask

  task automatic cyc();
    #1;
    model_check();
    model_update();
    @(posedge clk);
    @(negedge clk);
    fl_en = 0; fa_en = 0; fi_en = 0;
  endtask

  task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic [1:0] k);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_kind = k;
    #1;
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [AW-1:0] a,
                      input logic [3:0] rwxg);
    fl_en = 1; fl_vpn = v; fl_pfn = p; fl_asid = a;
    {fl_rd, fl_wr, fl_ex, fl_glb} = rwxg;
    cyc();
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_r[i] = 0; m_w[i] = 0; m_x[i] = 0; m_g[i] = 0;
      m_vpn[i] = 0; m_pfn[i] = 0; m_asid[i] = 0;
    end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    look(20'd5, 16'd1, 2'd0);
    chk("R1 reset miss", PW'(lk_miss), 1);
    chk("R1 reset no hit", PW'(lk_hit), 0);
    cyc();

    for (int i = 0; i < N; i++) fill(20'(100 + i), 24'h500 + 24'(i), (i == 5) ? 16'd2 : 16'd1, 4'b1000);
    look(20'd105, 16'd1, 2'd0);
    chk("R2 asid mismatch miss", PW'(lk_hit), 0);
    look(20'd105, 16'd2, 2'd0);
    chk("R2 asid match hit", PW'(lk_hit), 1);
    chk("R3 pfn on hit", lk_pfn, 24'h505);
    look(20'd100, 16'd1, 2'd1);
    chk("R4 write to read-only faults", PW'(lk_fault), 1);
    look(20'd100, 16'd1, 2'd0);
    chk("R4 read allowed", PW'(lk_fault), 0);
    cyc();

    fi_en = 1; fi_asid = 16'd2; cyc();
    look(20'd105, 16'd2, 2'd0);
    chk("R9 flushed by id", PW'(lk_miss), 1);
    look(20'd104, 16'd1, 2'd0);
    chk("R9 other id kept", PW'(lk_hit), 1);

    fill(20'd300, 24'h300, 16'd1, 4'b1110);
    fill(20'd301, 24'h301, 16'd1, 4'b1110);
    look(20'd100, 16'd1, 2'd0);
    chk("R7 slot 0 evicted first", PW'(lk_miss), 1);
    look(20'd300, 16'd1, 2'd2);
    chk("R6 fill into free slot kept", PW'(lk_hit), 1);
    chk("R4 execute allowed", PW'(lk_fault), 0);
    look(20'd101, 16'd1, 2'd0);
    chk("R6 free slot used, slot 1 kept", PW'(lk_hit), 1);
    fill(20'd302, 24'h302, 16'd1, 4'b1000);
    look(20'd101, 16'd1, 2'd0);
    chk("R7 slot 1 evicted next", PW'(lk_miss), 1);
    look(20'd302, 16'd1, 2'd0);
    chk("R5 fill visible next cycle", PW'(lk_hit), 1);

    fill(20'd110, 24'hAAA, 16'd1, 4'b1000);
    look(20'd110, 16'd1, 2'd0);
    chk("R10 lowest index wins", lk_pfn, 24'hAAA);

    fill(20'd400, 24'h400, 16'd3, 4'b1001);
    look(20'd400, 16'd9, 2'd0);
    chk("R2 global ignores asid", PW'(lk_hit), 1);
    fi_en = 1; fi_asid = 16'd3; cyc();
    look(20'd400, 16'd9, 2'd0);
    chk("R9 global survives id flush", PW'(lk_hit), 1);
    fa_en = 1; cyc();
    look(20'd400, 16'd9, 2'd0);
    chk("R8 flush all", PW'(lk_miss), 1);

    fill(20'd401, 24'h401, 16'd1, 4'b1000);
    fa_en = 1;
    fill(20'd500, 24'h555, 16'd1, 4'b1000);
    look(20'd500, 16'd1, 2'd0);
    chk("R12 fill survives same-cycle flush", lk_pfn, 24'h555);
    look(20'd401, 16'd1, 2'd0);
    chk("R12 other entry flushed", PW'(lk_miss), 1);

    lk_valid = 0; lk_vpn = 20'd500; #1;
    chk("R11 idle no hit", PW'(lk_hit), 0);
    chk("R11 idle no miss", PW'(lk_miss), 0);
    cyc();

    for (int n = 0; n < 3000; n++) begin
      lk_valid = ($urandom % 8) != 0;
      lk_vpn   = VW'($urandom % 24);
      lk_asid  = AW'($urandom % 4);
      lk_kind  = 2'($urandom);
      fl_en    = ($urandom % 3) == 0;
      fl_vpn   = VW'($urandom % 24);
      fl_pfn   = PW'($urandom);
      fl_asid  = AW'($urandom % 4);
      {fl_rd, fl_wr, fl_ex} = 3'($urandom);
      fl_glb   = ($urandom % 6) == 0;
      fa_en    = ($urandom % 97) == 0;
      fi_en    = ($urandom % 19) == 0;
      fi_asid  = AW'($urandom % 4);
      cyc();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule